// File: doc/BRIEF.md
# Pulse Capture Buffer Controller

This block drives the write port of a dual-port sample RAM that runs as a circular buffer. On every accepted sample it writes the in-phase and quadrature words at the current write pointer and advances the pointer. A detector supplies a pulse-present indication. When a pulse begins, the block opens a capture record. The record reaches back a fixed number of samples before the trigger, covers every sample of the pulse, and runs on for a fixed number of samples after the pulse ends.

When the pulse starts, the block latches a free-running cycle counter as the time stamp of the record. When the record closes, it writes one directory word into an external status FIFO. The word holds the time stamp, the first RAM address of the record and its last RAM address. A host reads the records through the RAM's other port, using the directory to find them.

There are four states, all defined in `pcap_pkg`:

- IDLE: waiting for a trigger. The transition IDLE→PULSE (trigger) happens on a valid sample with pulse-present high.
- PULSE: a pulse is in progress. The transition PULSE→TAIL (pulse end) happens on a valid sample with pulse-present low. PULSE→PUSH (immediate close) replaces it when the post-trigger count is one.
- TAIL: the post-trigger window is running. TAIL→PULSE (extend) happens on a valid sample with pulse-present high. TAIL→PUSH (close) happens on the last valid sample of the window.
- PUSH: the directory word is being written. PUSH→IDLE (done) is unconditional. Pulse-present is not examined while in PUSH.

Top module: `pcap_ctrl`

## Requirements
- R1: Every cycle with `smp_valid` high raises `ram_we` in that same cycle, with `ram_addr` equal to the write pointer and `ram_wdata` = {I, Q}. I occupies the upper half of `ram_wdata`. The pointer starts at 0 after reset and advances by one per valid sample, modulo 2^DEPTH_LOG2. With `smp_valid` low, `ram_we` is low and the pointer holds.
- R2: A TS_W-bit time stamp counter starts at 0 when reset is released, increments every clock and wraps silently. A record's time stamp is the counter value in the cycle in which its triggering sample is accepted.
- R3: The start address of a record is the address of its triggering sample minus PRE_CNT, modulo the RAM depth.
- R4: A record closes on the POST_CNT-th consecutive valid sample with `pulse_present` low. Its end address is the address of that sample. The directory push happens in the following cycle.
- R5: The directory word is laid out as {time stamp, start address, end address}, with the end address in the low DEPTH_LOG2 bits. `fifo_we` is high for exactly one cycle per closed record.
- R6: A valid sample with `pulse_present` high during the post-trigger window extends the current record and restarts the window. No second record is opened, and the first time stamp and start address are kept.
- R7: If `fifo_full` is high in the push cycle, the record is dropped: no `fifo_we`, and `ovf_flag` is set. `ovf_flag` stays set until reset.
- R8: After reset, `ram_addr` is 0, and `fifo_we` and `ovf_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_i | input | SAMP_W | In-phase sample |
| smp_q | input | SAMP_W | Quadrature sample |
| pulse_present | input | 1 | Detector output, sampled on valid samples |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | DEPTH_LOG2 | RAM write address |
| ram_wdata | output | 2*SAMP_W | RAM write data {I, Q} |
| fifo_full | input | 1 | Status FIFO cannot accept a word |
| fifo_we | output | 1 | Status FIFO write strobe |
| fifo_wdata | output | TS_W+2*DEPTH_LOG2 | Directory word {time stamp, start, end} |
| ovf_flag | output | 1 | Sticky: a record was dropped |

## Verification
The bench builds the block with DEPTH_LOG2=5, PRE_CNT=4, POST_CNT=3 and TS_W=8. The shallow 32-entry buffer makes the very first record's start address wrap below zero, and its end addresses cross the top of the buffer within a few records. The 8-bit time stamp wraps after 256 cycles, so a short idle stretch is enough to show silent wrap. A post window of three samples leaves room to re-trigger partway through it, and to insert invalid cycles that must not count toward the window.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PULSE = 2'd1,
        S_TAIL  = 2'd2,
        S_PUSH  = 2'd3
    } cap_state_t;
endpackage

// File: rtl/pcap_wptr.sv
module pcap_wptr #(
    parameter int A_W    = 10,
    parameter int SAMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMP_W-1:0]   smp_i,
    input  logic [SAMP_W-1:0]   smp_q,
    output logic                ram_we,
    output logic [A_W-1:0]      ram_addr,
    output logic [2*SAMP_W-1:0] ram_wdata
);
    logic [A_W-1:0] wptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         wptr_q <= '0;
        else if (smp_valid) wptr_q <= wptr_q + 1'b1;
    end

    always_comb begin
        ram_we    = smp_valid;
        ram_addr  = wptr_q;
        ram_wdata = {smp_i, smp_q};
    end
endmodule

// File: rtl/pcap_tstamp.sv
module pcap_tstamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_now
);
    always_ff @(posedge clk) begin
        if (!rst_n) ts_now <= '0;
        else        ts_now <= ts_now + 1'b1;
    end
endmodule

// File: rtl/pcap_fsm.sv
module pcap_fsm
    import pcap_pkg::*;
#(
    parameter int A_W  = 10,
    parameter int TS_W = 32,
    parameter int PRE  = 16,
    parameter int POST = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic                    pulse_present,
    input  logic [A_W-1:0]          wptr,
    input  logic [TS_W-1:0]         ts_now,
    input  logic                    fifo_full,
    output logic                    fifo_we,
    output logic [TS_W+2*A_W-1:0]   fifo_wdata,
    output logic                    ovf_flag
);
    localparam int PC_W = $clog2(POST + 1);
    localparam logic [A_W-1:0]  PRE_A     = A_W'(PRE);
    localparam logic [PC_W-1:0] POST_LAST = PC_W'(POST - 1);

    cap_state_t      state, nstate;
    logic [TS_W-1:0] ts_q;
    logic [A_W-1:0]  start_q, end_q;
    logic [PC_W-1:0] post_q;
    logic            post_hit;

    // Is the current valid, pulse-low sample the last of the post window?
    always_comb begin
        if (state == S_PULSE) post_hit = (POST == 1);
        else                  post_hit = (post_q == POST_LAST);
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (smp_valid && pulse_present) nstate = S_PULSE;
            S_PULSE: if (smp_valid && !pulse_present)
                         nstate = post_hit ? S_PUSH : S_TAIL;
            S_TAIL:  if (smp_valid) begin
                         if (pulse_present) nstate = S_PULSE;
                         else if (post_hit) nstate = S_PUSH;
                     end
            S_PUSH:  nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q     <= '0;
            start_q  <= '0;
            end_q    <= '0;
            post_q   <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (state == S_IDLE && smp_valid && pulse_present) begin
                ts_q    <= ts_now;
                start_q <= wptr - PRE_A;
            end
            if (state == S_PULSE && smp_valid && !pulse_present)
                post_q <= PC_W'(1);
            if (state == S_TAIL && smp_valid)
                post_q <= pulse_present ? '0 : post_q + 1'b1;
            if (nstate == S_PUSH && state != S_PUSH)
                end_q <= wptr;
            if (state == S_PUSH && fifo_full)
                ovf_flag <= 1'b1;
        end
    end

    always_comb begin
        fifo_we    = (state == S_PUSH) && !fifo_full;
        fifo_wdata = {ts_q, start_q, end_q};
    end
endmodule

// File: rtl/pcap_ctrl.sv
module pcap_ctrl #(
    parameter int DEPTH_LOG2 = 10,
    parameter int SAMP_W     = 8,
    parameter int TS_W       = 32,
    parameter int PRE_CNT    = 16,
    parameter int POST_CNT   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [SAMP_W-1:0]            smp_i,
    input  logic [SAMP_W-1:0]            smp_q,
    input  logic                         pulse_present,
    output logic                         ram_we,
    output logic [DEPTH_LOG2-1:0]        ram_addr,
    output logic [2*SAMP_W-1:0]          ram_wdata,
    input  logic                         fifo_full,
    output logic                         fifo_we,
    output logic [TS_W+2*DEPTH_LOG2-1:0] fifo_wdata,
    output logic                         ovf_flag
);
    logic [TS_W-1:0] ts_now;

    pcap_wptr #(.A_W(DEPTH_LOG2), .SAMP_W(SAMP_W)) u_wptr (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_i(smp_i), .smp_q(smp_q),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    pcap_tstamp #(.TS_W(TS_W)) u_ts (
        .clk(clk), .rst_n(rst_n), .ts_now(ts_now)
    );

    pcap_fsm #(.A_W(DEPTH_LOG2), .TS_W(TS_W), .PRE(PRE_CNT), .POST(POST_CNT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .pulse_present(pulse_present), .wptr(ram_addr), .ts_now(ts_now),
        .fifo_full(fifo_full), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
        .ovf_flag(ovf_flag)
    );
endmodule

// File: rtl/pcap_ctrl_chk.sv
module pcap_ctrl_chk #(
    parameter int A_W = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ram_we,
    input logic [A_W-1:0] ram_addr,
    input logic           fifo_full,
    input logic           fifo_we,
    input logic           ovf_flag
);
    assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> ram_addr == $past(ram_addr) + 1'b1);

    assert_ptr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we |=> $stable(ram_addr));

    assert_single_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we |=> !fifo_we);

    assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_we);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);
endmodule

bind pcap_ctrl pcap_ctrl_chk #(.A_W(DEPTH_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_addr(ram_addr),
    .fifo_full(fifo_full), .fifo_we(fifo_we), .ovf_flag(ovf_flag)
);

// File: tb/pcap_ctrl_bench.sv
module pcap_ctrl_bench;
    localparam int A  = 5;
    localparam int SW = 8;
    localparam int TW = 8;
    localparam int PRE = 4;
    localparam int POST = 3;
    localparam int WW = TW + 2*A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic smp_valid = 1'b0, pulse_present = 1'b0, fifo_full = 1'b0;
    logic [SW-1:0] smp_i = '0, smp_q = '0;
    logic ram_we, fifo_we, ovf_flag;
    logic [A-1:0] ram_addr;
    logic [2*SW-1:0] ram_wdata;
    logic [WW-1:0] fifo_wdata;

    pcap_ctrl #(.DEPTH_LOG2(A), .SAMP_W(SW), .TS_W(TW), .PRE_CNT(PRE), .POST_CNT(POST))
    u_pcap_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .pulse_present(pulse_present), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .fifo_full(fifo_full), .fifo_we(fifo_we),
        .fifo_wdata(fifo_wdata), .ovf_flag(ovf_flag)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0, pushes = 0;
    int cyc = 0;
    logic [A-1:0] ref_wp = '0;
    logic [WW-1:0] last_word = '0;
    bit done = 0;
    logic [TW-1:0] exp_ts;
    logic [A-1:0] exp_start, exp_end;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 0; ref_wp <= '0;
        end else begin
            cyc <= cyc + 1;
            if (smp_valid) ref_wp <= ref_wp + 1'b1;
            if (fifo_we) begin pushes <= pushes + 1; last_word <= fifo_wdata; end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the write port (R1)
    task automatic smp(input bit v, input bit p, input bit trig, input bit last);
        @(negedge clk);
        smp_valid = v; pulse_present = p;
        smp_i = SW'(ref_wp * 3 + 1); smp_q = ~smp_i;
        if (trig) begin
            exp_ts = TW'(cyc);
            exp_start = ref_wp - A'(PRE);
        end
        if (last) exp_end = ref_wp;
        #1;
        chk(ram_we == v, "R1 we", ram_we, v);
        if (v) begin
            chk(ram_addr == ref_wp, "R1 addr", ram_addr, ref_wp);
            chk(ram_wdata == {smp_i, smp_q}, "R1 data", ram_wdata, {smp_i, smp_q});
        end
    endtask

    task automatic chk_word(input string tag);
        chk(last_word[WW-1 -: TW] == exp_ts, {tag, " R2 ts"}, last_word[WW-1 -: TW], exp_ts);
        chk(last_word[2*A-1 -: A] == exp_start, {tag, " R3 start"}, last_word[2*A-1 -: A], exp_start);
        chk(last_word[A-1:0] == exp_end, {tag, " R4 end"}, last_word[A-1:0], exp_end);
    endtask

    // Pulse of n_on samples, optional invalid cycle after each sample
    task automatic record(input int n_on, input bit gaps);
        for (int k = 0; k < n_on; k++) begin
            smp(1, 1, k == 0, 0);
            if (gaps) smp(0, 0, 0, 0);
        end
        for (int k = 0; k < POST; k++) begin
            smp(1, 0, 0, k == POST - 1);
            if (gaps && k != POST - 1) smp(0, 1, 0, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ram_addr == '0, "R8 addr", ram_addr, 0);
        chk(fifo_we == 0, "R8 fifo_we", fifo_we, 0);
        chk(ovf_flag == 0, "R8 ovf", ovf_flag, 0);
    endtask

    task automatic t_basic();
        int p0 = pushes;
        record(3, 0);
        smp(0, 0, 0, 0);
        chk(fifo_we == 1, "R4 push cycle", fifo_we, 1);
        @(posedge clk); #1;
        chk(pushes == p0 + 1, "R5 one push", pushes, p0 + 1);
        chk_word("basic");
        smp(0, 0, 0, 0);
        chk(fifo_we == 0, "R5 strobe width", fifo_we, 0);
    endtask

    task automatic t_gaps();
        int p0 = pushes;
        record(2, 1);
        smp(0, 0, 0, 0);
        @(posedge clk); #1;
        chk(pushes == p0 + 1, "R1 gaps push", pushes, p0 + 1);
        chk_word("gaps");
    endtask

    task automatic t_extend();
        int p0 = pushes;
        smp(1, 1, 1, 0);
        smp(1, 1, 0, 0);
        for (int k = 0; k < POST - 1; k++) smp(1, 0, 0, 0);
        chk(pushes == p0, "R6 no early push", pushes, p0);
        smp(1, 1, 0, 0);
        for (int k = 0; k < POST; k++) smp(1, 0, 0, k == POST - 1);
        smp(0, 0, 0, 0);
        @(posedge clk); #1;
        chk(pushes == p0 + 1, "R6 single record", pushes, p0 + 1);
        chk_word("extend R6");
    endtask

    task automatic t_overflow();
        int p0 = pushes;
        fifo_full = 1'b1;
        record(1, 0);
        smp(0, 0, 0, 0);
        chk(fifo_we == 0, "R7 no we when full", fifo_we, 0);
        smp(0, 0, 0, 0);
        fifo_full = 1'b0;
        chk(pushes == p0, "R7 dropped", pushes, p0);
        chk(ovf_flag == 1, "R7 ovf set", ovf_flag, 1);
        record(2, 0);
        smp(0, 0, 0, 0);
        @(posedge clk); #1;
        chk(pushes == p0 + 1, "R7 later push", pushes, p0 + 1);
        chk_word("after ovf R7");
        chk(ovf_flag == 1, "R7 ovf sticky", ovf_flag, 1);
    endtask

    task automatic t_tswrap();
        for (int k = 0; k < 300; k++) smp(0, 0, 0, 0);
        chk(cyc > 256, "R2 past wrap", cyc, 257);
        record(1, 0);
        smp(0, 0, 0, 0);
        @(posedge clk); #1;
        chk_word("ts wrap R2");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_basic();
        t_gaps();
        t_extend();
        for (int r = 0; r < 3; r++) t_basic();
        t_overflow();
        t_tswrap();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule